// File: doc/BRIEF.md
# Backlight PWM Generator with Byte Register Control

This block generates the single pulse-width-modulated signal that dims a display backlight. It also drives a separate backlight power enable. A host programs it through a byte-wide write strobe and address, and reads the registers back through a combinational read port. Three registers sit at fixed addresses. The control register holds a run bit and a 7-bit prescale field. The level register holds an 8-bit duty level. The power register drives the backlight enable pin.

The prescaler divides the block clock by the field value plus one. Every PWM period is 256 of these divided ticks long. The output is high from the start of a period for as many ticks as the duty level. The period engine has two named states. `ST_IDLE` holds the counters cleared and the output low. `ST_RUN` counts ticks. The transition `GO` (IDLE to RUN) is taken on the clock after the run bit is seen set, and it captures the level and prescale registers into shadow copies. The transition `HALT` (RUN to IDLE) is taken when the run bit is cleared. Inside `ST_RUN`, the `WRAP` step from count 255 to count 0 refreshes the shadows. Host writes therefore never cut a period short. The host's usual sequence (clear the control register, then write the new prescale value with the run bit set) restarts the output cleanly.

Top module: `bl_pwm_gen`

## Requirements
- R1: The control register sits at address 0x4B, the level register at 0x4E and the power register at 0x51. Each reads back the full byte last written to it, and all three read 0x00 after reset. A read of any other address returns 0x00.
- R2: A write to any other address changes no register, no output and no read-back value.
- R3: `bl_en` equals bit 0 of the power register and changes on the clock edge that writes it. Neither the run bit nor the PWM activity affects it, and it does not affect them.
- R4: Bit 7 of the control register is the run bit. From the clock edge that writes it to 0, `pwm_out` is low, and it stays low until the run bit is set again.
- R5: Bits 6:0 of the control register hold the prescale field F. Each PWM period lasts exactly 256*(F+1) clock cycles, and consecutive periods follow with no gap.
- R6: With level L below 255, `pwm_out` is high for the first L*(F+1) cycles of every period and low for the rest. L = 0 gives a constantly low output. L = 255 keeps the output high for the whole period.
- R7: After the run bit is set from the stopped state, the first period starts one clock after the writing edge. It starts with a full-length high phase when L > 0, so a restart after the clear-then-reload sequence produces no runt pulse.
- R8: A level or prescale value written during a period takes effect only at the next period boundary. The current period completes with the old values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock (nominally 6 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| addr | input | 8 | Register address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| pwm_out | output | 1 | Active-high PWM output |
| bl_en | output | 1 | Backlight power enable |

## Verification
Register read-back and `bl_en` are due in the cycle after the writing edge. The bench samples them at the following falling edge. Clearing the run bit forces `pwm_out` low in that same cycle. Setting it makes the first period begin one edge later still, so each period measurement starts at the second falling edge after the enabling write. The measurement then counts high samples over exactly 256*(F+1) falling edges and checks that the next period restarts high. For deferred updates, the bench writes new values during a period, then measures that period and the one after it back to back against the old and the new expected widths.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam logic [ADDR_W-1:0] CTRL_ADDR  = 8'h4B;
    localparam logic [ADDR_W-1:0] LEVEL_ADDR = 8'h4E;
    localparam logic [ADDR_W-1:0] POWER_ADDR = 8'h51;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] CTRL_A  = 8'h4B,
    parameter logic [ADDR_W-1:0] LEVEL_A = 8'h4E,
    parameter logic [ADDR_W-1:0] POWER_A = 8'h51
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              run_bit,
    output logic [DATA_W-2:0] div_field,
    output logic [DATA_W-1:0] level,
    output logic              power_bit
);
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] level_q;
    logic [DATA_W-1:0] power_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            level_q <= '0;
            power_q <= '0;
        end else if (wr_en) begin
            if (addr == CTRL_A)  ctrl_q  <= wdata;
            if (addr == LEVEL_A) level_q <= wdata;
            if (addr == POWER_A) power_q <= wdata;
        end
    end

    always_comb begin
        if (addr == CTRL_A)       rdata = ctrl_q;
        else if (addr == LEVEL_A) rdata = level_q;
        else if (addr == POWER_A) rdata = power_q;
        else                      rdata = '0;
    end

    assign run_bit   = ctrl_q[DATA_W-1];
    assign div_field = ctrl_q[DATA_W-2:0];
    assign level     = level_q;
    assign power_bit = power_q[0];

    logic unused_power;
    assign unused_power = ^power_q[DATA_W-1:1];
endmodule

// File: rtl/bl_pwm_presc.sv
module bl_pwm_presc #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (clr)        cnt_q <= '0;
        else if (cnt_q == div) cnt_q <= '0;
        else                 cnt_q <= cnt_q + 1'b1;
    end

    assign tick = !clr && (cnt_q == div);
endmodule

// File: rtl/bl_pwm_core.sv
module bl_pwm_core
    import bl_pwm_pkg::*;
#(
    parameter int CNT_W = 8,
    localparam int DIV_W = CNT_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_bit,
    input  logic [DIV_W-1:0] div_field,
    input  logic [CNT_W-1:0] level,
    input  logic             tick,
    output logic             presc_clr,
    output logic [DIV_W-1:0] div_sh,
    output logic             pwm_out
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    run_state_e       state, state_nxt;
    logic [CNT_W-1:0] per_cnt;
    logic [CNT_W-1:0] duty_sh;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // transitions GO and HALT
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (run_bit)  state_nxt = ST_RUN;
            ST_RUN:  if (!run_bit) state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // period counter and shadow copies
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_cnt <= '0;
            duty_sh <= '0;
            div_sh  <= '0;
        end else if (state == ST_IDLE) begin
            per_cnt <= '0;
            if (run_bit) begin
                duty_sh <= level;
                div_sh  <= div_field;
            end
        end else if (!run_bit) begin
            per_cnt <= '0;
        end else if (tick) begin
            per_cnt <= per_cnt + 1'b1;
            if (per_cnt == CNT_MAX) begin
                duty_sh <= level;
                div_sh  <= div_field;
            end
        end
    end

    // outputs
    always_comb begin
        presc_clr = 1'b1;
        pwm_out   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                presc_clr = 1'b1;
                pwm_out   = 1'b0;
            end
            ST_RUN: begin
                presc_clr = !run_bit;
                pwm_out   = run_bit && ((duty_sh == CNT_MAX) || (per_cnt < duty_sh));
            end
            default: begin
                presc_clr = 1'b1;
                pwm_out   = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/bl_pwm_gen.sv
module bl_pwm_gen
    import bl_pwm_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CTRL_A  = CTRL_ADDR,
    parameter logic [ADDR_W-1:0] LEVEL_A = LEVEL_ADDR,
    parameter logic [ADDR_W-1:0] POWER_A = POWER_ADDR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              pwm_out,
    output logic              bl_en
);
    localparam int DIV_W = DATA_W - 1;

    logic             run_bit;
    logic [DIV_W-1:0] div_field;
    logic [DIV_W-1:0] div_sh;
    logic [DATA_W-1:0] level;
    logic             presc_clr;
    logic             tick;

    bl_pwm_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .CTRL_A(CTRL_A), .LEVEL_A(LEVEL_A), .POWER_A(POWER_A)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .run_bit(run_bit), .div_field(div_field),
        .level(level), .power_bit(bl_en)
    );

    bl_pwm_presc #(.DIV_W(DIV_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .clr(presc_clr), .div(div_sh), .tick(tick)
    );

    bl_pwm_core #(.CNT_W(DATA_W)) u_core (
        .clk(clk), .rst_n(rst_n), .run_bit(run_bit), .div_field(div_field),
        .level(level), .tick(tick), .presc_clr(presc_clr), .div_sh(div_sh),
        .pwm_out(pwm_out)
    );
endmodule

// File: rtl/bl_pwm_chk.sv
module bl_pwm_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] CTRL_A  = 8'h4B,
    parameter logic [ADDR_W-1:0] LEVEL_A = 8'h4E,
    parameter logic [ADDR_W-1:0] POWER_A = 8'h51
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              pwm_out,
    input logic              bl_en,
    input logic              run,
    input logic [DATA_W-1:0] per_cnt,
    input logic [DATA_W-1:0] duty_sh
);
    localparam logic [DATA_W-1:0] ONE = 1;

    AST_LEVEL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && $past(addr) == LEVEL_A && addr == LEVEL_A) |-> rdata == $past(wdata)); // R1

    AST_POWER_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == POWER_A) |=> bl_en == $past(wdata[0])); // R3

    AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == CTRL_A && !wdata[DATA_W-1]) |=> !pwm_out); // R4

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && per_cnt != $past(per_cnt)) |-> per_cnt == $past(per_cnt) + ONE); // R5

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && per_cnt != '0) |-> $stable(duty_sh)); // R8
endmodule

bind bl_pwm_gen bl_pwm_chk #(
    .ADDR_W(bl_pwm_pkg::ADDR_W), .DATA_W(bl_pwm_pkg::DATA_W),
    .CTRL_A(CTRL_A), .LEVEL_A(LEVEL_A), .POWER_A(POWER_A)
) i_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pwm_out(pwm_out), .bl_en(bl_en),
    .run(u_core.state == bl_pwm_pkg::ST_RUN),
    .per_cnt(u_core.per_cnt), .duty_sh(u_core.duty_sh)
);

// File: tb/test_bl_pwm_gen.sv
module test_bl_pwm_gen;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_CTRL  = 8'h4B;
    localparam logic [7:0] A_LEVEL = 8'h4E;
    localparam logic [7:0] A_POWER = 8'h51;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       pwm_out;
    logic       bl_en;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bl_pwm_gen i_bl_pwm_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pwm_out(pwm_out), .bl_en(bl_en)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // returns at the falling edge after the writing edge
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input logic [7:0] a, input logic [7:0] exp, input string req);
        addr = a;
        #1;
        check(rdata == exp, req, rdata, exp);
    endtask

    // count high samples over n falling edges
    task automatic count_high(input int n, output int highs, output bit first);
        highs = 0;
        first = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == 0) first = pwm_out;
            if (pwm_out) highs++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int highs;
        bit first;
        int lv [6] = '{0, 1, 2, 127, 254, 255};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_check(A_CTRL, 8'h00, "R1");
        rd_check(A_LEVEL, 8'h00, "R1");
        rd_check(A_POWER, 8'h00, "R1");
        check(pwm_out == 1'b0, "R4", pwm_out, 0);
        check(bl_en == 1'b0, "R3", bl_en, 0);

        // R1 read-back of full bytes
        wr(A_LEVEL, 8'hA5); rd_check(A_LEVEL, 8'hA5, "R1");
        wr(A_POWER, 8'h5A); rd_check(A_POWER, 8'h5A, "R1");
        check(bl_en == 1'b0, "R3", bl_en, 0);
        wr(A_CTRL, 8'h3C);  rd_check(A_CTRL, 8'h3C, "R1");
        check(pwm_out == 1'b0, "R4", pwm_out, 0);
        rd_check(8'h4C, 8'h00, "R1");

        // R2 other addresses ignored
        for (int a = 8'h40; a < 8'h58; a++) begin
            if (a != A_CTRL && a != A_LEVEL && a != A_POWER) wr(8'(a), 8'hFF);
        end
        rd_check(A_CTRL, 8'h3C, "R2");
        rd_check(A_LEVEL, 8'hA5, "R2");
        rd_check(A_POWER, 8'h5A, "R2");
        check(bl_en == 1'b0 && pwm_out == 1'b0, "R2", {bl_en, pwm_out}, 0);
        rd_check(8'h50, 8'h00, "R2");

        // R3 power bit follows bit 0
        wr(A_POWER, 8'h01);
        check(bl_en == 1'b1, "R3", bl_en, 1);
        wr(A_CTRL, 8'h00);

        // R5 R6 R7 sweep of prescale and level
        for (int f = 0; f < 4; f++) begin
            for (int k = 0; k < 6; k++) begin
                int per;
                int exp_h;
                per = 256 * (f + 1);
                exp_h = (lv[k] == 255) ? per : lv[k] * (f + 1);
                wr(A_LEVEL, 8'(lv[k]));
                wr(A_CTRL, 8'(8'h80 | f));
                check(pwm_out == 1'b0, "R7", pwm_out, 0);
                count_high(per, highs, first);
                check(highs == exp_h, "R6", highs, exp_h);
                check(first == (lv[k] != 0), "R7", first, lv[k] != 0);
                if (lv[k] != 0 && lv[k] != 255) begin
                    @(negedge clk);
                    check(pwm_out == 1'b1, "R5", pwm_out, 1);
                end
                check(bl_en == 1'b1, "R3", bl_en, 1);
                wr(A_CTRL, 8'h00);
                check(pwm_out == 1'b0, "R4", pwm_out, 0);
            end
        end

        // R5 longest period, with power bit off
        wr(A_POWER, 8'h00);
        wr(A_LEVEL, 8'd128);
        wr(A_CTRL, 8'hFF);
        count_high(256 * 128, highs, first);
        check(highs == 128 * 128, "R5", highs, 128 * 128);
        @(negedge clk);
        check(pwm_out == 1'b1, "R5", pwm_out, 1);
        check(bl_en == 1'b0, "R3", bl_en, 0);
        wr(A_CTRL, 8'h00);
        check(pwm_out == 1'b0, "R4", pwm_out, 0);
        repeat (20) @(negedge clk);
        check(pwm_out == 1'b0, "R4", pwm_out, 0);

        // R8 deferred update of level and prescale
        wr(A_LEVEL, 8'd10);
        wr(A_CTRL, 8'h80);
        highs = 0;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            if (pwm_out) highs++;
            if (i == 3) begin wr_en = 1'b1; addr = A_CTRL; wdata = 8'h81; end
            if (i == 4) begin addr = A_LEVEL; wdata = 8'd200; end
            if (i == 5) wr_en = 1'b0;
        end
        check(highs == 10, "R8", highs, 10);
        count_high(512, highs, first);
        check(highs == 400, "R8", highs, 400);
        check(first == 1'b1, "R8", first, 1);
        @(negedge clk);
        check(pwm_out == 1'b1, "R8", pwm_out, 1);
        wr(A_CTRL, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule